// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and the calendar in packed BCD. A base tick enable feeds a sub-second divider; every `SUBSEC_DIV` tick pulses it advances the seconds, and carries ripple through minutes, hours, day-of-week, day-of-month, month, the two-digit year and a century bit within the same clock edge. Hours run in either a 12-hour form with a PM flag or a 24-hour form, chosen by a mode field. Month lengths follow the calendar, and February gains a 29th day when the two-digit year is a multiple of four.

Software writes and reads each field through a simple register port with eight addresses. Downstream interrupt logic consumes four single-cycle strobes that mark a new second, a new minute, a new hour and the first day of a new month.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hour 0x12 (midnight in 12-hour form), day-of-week 0, day-of-month 01, month 01, year 00, century 0 and mode 0 (12-hour); all strobes are low.
- R2: Seconds (address 0) and minutes (address 1) hold BCD 00 to 59 in bits 6:0; 59 wraps to 00 and carries into the next field.
- R3: With mode bit 0 of address 7 set (24-hour), the hour (address 2, bits 5:0) counts BCD 00 to 23, and 23 to 00 carries into both day fields.
- R4: With mode bit 0 clear (12-hour), the hour holds BCD 01 to 12 in bits 4:0 and a PM flag in bit 5; 11 to 12 inverts the PM flag, 12 to 01 keeps it, and only the PM 11 to AM 12 step carries into the day fields.
- R5: Day-of-week (address 3, bits 2:0) counts 0 to 6 and wraps to 0 on each day carry.
- R6: Day-of-month (address 4, BCD) wraps to 01 after 30 for months 04, 06, 09, 11, after 31 for other months, and after 28 in February, or 29 when the two-digit year is a multiple of four.
- R7: Month (address 5, bits 4:0, BCD 01 to 12) wraps to 01 and carries into the year (address 6, BCD 00 to 99); a year step from 99 to 00 inverts the century bit (address 5, bit 7).
- R8: Seconds advance once every `SUBSEC_DIV` tick pulses; a write to the seconds field clears the divider, so the next advance follows exactly `SUBSEC_DIV` ticks after the write.
- R9: A field written in the same cycle as its own increment takes the written value, and a carry out of that field is dropped in that cycle; a seconds write in the cycle of a divider wrap suppresses that advance.
- R10: `sec_pulse` is high for one cycle with each seconds advance, `min_pulse` when seconds wrap, `hour_pulse` when minutes wrap, and `month_pulse` when the day-of-month wraps to 01; each is high in the cycle where the advanced value is held.
- R11: `rd_data` returns the field at `rd_addr` one cycle later, with unused bits reading 0 (address 7 returns only the mode bit in bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Base enable for the sub-second divider |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field address for a write |
| wr_data | input | 8 | Write value |
| rd_addr | input | 3 | Field address for a read |
| rd_data | output | 8 | Registered read value |
| sec_pulse | output | 1 | New-second strobe |
| min_pulse | output | 1 | New-minute strobe |
| hour_pulse | output | 1 | New-hour strobe |
| month_pulse | output | 1 | New-month strobe |

## Verification
A write lands at the clock edge where it is presented, and the counters and all four strobes update at the edge that carries the last tick of a second, so the bench samples strobes on the falling edge right after that tick. Read data is registered, so the bench sets `rd_addr` on one falling edge and samples `rd_data` one full cycle later, only while no tick is applied. Directed cases cover the carry corners and the same-cycle write conflicts, and random loads followed by random runs of seconds are compared against a bench calendar model.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam logic [2:0] ADDR_SEC  = 3'd0;
  localparam logic [2:0] ADDR_MIN  = 3'd1;
  localparam logic [2:0] ADDR_HOUR = 3'd2;
  localparam logic [2:0] ADDR_WDAY = 3'd3;
  localparam logic [2:0] ADDR_MDAY = 3'd4;
  localparam logic [2:0] ADDR_MON  = 3'd5;
  localparam logic [2:0] ADDR_YEAR = 3'd6;
  localparam logic [2:0] ADDR_MODE = 3'd7;

  // Add one to a packed two-digit BCD value (no range wrap).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic year_is_leap(input logic [7:0] yr);
    logic [6:0] b;
    b = bcd_to_bin(yr);
    return b[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_last_day(input logic [4:0] mon, input logic leap);
    case (mon)
      5'h02:                      return leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_subsec_div.sv
module rtc_subsec_div #(
  parameter int SUBSEC_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clear,
  output logic sec_tick
);
  localparam int CW = (SUBSEC_DIV > 2) ? $clog2(SUBSEC_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SUBSEC_DIV - 1);

  logic [CW-1:0] cnt;

  assign sec_tick = tick && !clear && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear)   cnt <= '0;
    else if (tick)      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  // R8
  div_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt == '0));
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sec_tick,
  input  logic       mode24,
  input  logic       wr_sec,
  input  logic       wr_min,
  input  logic       wr_hour,
  input  logic [7:0] wr_data,
  output logic [6:0] sec_q,
  output logic [6:0] min_q,
  output logic [5:0] hour_q,
  output logic       day_step,
  output logic       sec_pulse,
  output logic       min_pulse,
  output logic       hour_pulse
);
  logic       sec_wrap, min_wrap, hour_carry;
  logic [5:0] hour_nx;
  logic [7:0] sec_inc, min_inc, hour_inc;

  always_comb begin
    sec_inc  = bcd_inc({1'b0, sec_q});
    min_inc  = bcd_inc({1'b0, min_q});
    hour_inc = bcd_inc({3'b000, hour_q[4:0]});
    sec_wrap = sec_tick && !wr_sec && (sec_q == 7'h59);
    min_wrap = sec_wrap && !wr_min && (min_q == 7'h59);
    hour_carry = 1'b0;
    hour_nx    = hour_q;
    if (mode24) begin
      if (hour_q == 6'h23) begin
        hour_nx    = 6'h00;
        hour_carry = 1'b1;
      end else begin
        hour_inc = bcd_inc({2'b00, hour_q});
        hour_nx  = hour_inc[5:0];
      end
    end else begin
      if (hour_q[4:0] == 5'h11) begin
        hour_nx    = {~hour_q[5], 5'h12};
        hour_carry = hour_q[5];
      end else if (hour_q[4:0] == 5'h12) begin
        hour_nx = {hour_q[5], 5'h01};
      end else begin
        hour_nx = {hour_q[5], hour_inc[4:0]};
      end
    end
    day_step = min_wrap && !wr_hour && hour_carry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q      <= 7'h00;
      min_q      <= 7'h00;
      hour_q     <= 6'h12;
      sec_pulse  <= 1'b0;
      min_pulse  <= 1'b0;
      hour_pulse <= 1'b0;
    end else begin
      sec_pulse  <= sec_tick && !wr_sec;
      min_pulse  <= sec_wrap;
      hour_pulse <= min_wrap;
      if (wr_sec)        sec_q <= wr_data[6:0];
      else if (sec_tick) sec_q <= sec_wrap ? 7'h00 : sec_inc[6:0];
      if (wr_min)        min_q <= wr_data[6:0];
      else if (sec_wrap) min_q <= min_wrap ? 7'h00 : min_inc[6:0];
      if (wr_hour)       hour_q <= wr_data[5:0];
      else if (min_wrap) hour_q <= hour_nx;
    end
  end

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !wr_sec && sec_q == 7'h59) |=> (sec_q == 7'h00));
  // R4
  pm_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode24 && min_wrap && !wr_hour && hour_q[4:0] == 5'h11) |=> (hour_q[5] != $past(hour_q[5])));
  // R10
  min_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    min_pulse |-> (sec_q == 7'h00 && sec_pulse));
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       day_step,
  input  logic       wr_wday,
  input  logic       wr_mday,
  input  logic       wr_mon,
  input  logic       wr_year,
  input  logic [7:0] wr_data,
  output logic [2:0] wday_q,
  output logic [5:0] mday_q,
  output logic [4:0] mon_q,
  output logic [7:0] year_q,
  output logic       century_q,
  output logic       month_pulse
);
  logic       mday_wrap, mon_wrap, year_wrap;
  logic [7:0] mday_inc, mon_inc, year_inc, last_day;

  always_comb begin
    mday_inc  = bcd_inc({2'b00, mday_q});
    mon_inc   = bcd_inc({3'b000, mon_q});
    year_inc  = bcd_inc(year_q);
    last_day  = month_last_day(mon_q, year_is_leap(year_q));
    mday_wrap = day_step && !wr_mday && ({2'b00, mday_q} == last_day);
    mon_wrap  = mday_wrap && !wr_mon && (mon_q == 5'h12);
    year_wrap = mon_wrap && !wr_year && (year_q == 8'h99);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wday_q      <= 3'd0;
      mday_q      <= 6'h01;
      mon_q       <= 5'h01;
      year_q      <= 8'h00;
      century_q   <= 1'b0;
      month_pulse <= 1'b0;
    end else begin
      month_pulse <= mday_wrap;
      if (wr_wday)       wday_q <= wr_data[2:0];
      else if (day_step) wday_q <= (wday_q == 3'd6) ? 3'd0 : wday_q + 3'd1;
      if (wr_mday)       mday_q <= wr_data[5:0];
      else if (day_step) mday_q <= mday_wrap ? 6'h01 : mday_inc[5:0];
      if (wr_mon) begin
        mon_q     <= wr_data[4:0];
        century_q <= wr_data[7];
      end else begin
        if (mday_wrap) mon_q <= mon_wrap ? 5'h01 : mon_inc[4:0];
        if (year_wrap) century_q <= ~century_q;
      end
      if (wr_year)       year_q <= wr_data;
      else if (mon_wrap) year_q <= year_wrap ? 8'h00 : year_inc;
    end
  end

  // R5
  wday_range_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_wday && wday_q <= 3'd6) |=> (wday_q <= 3'd6));
  // R7
  century_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (year_wrap && !wr_mon) |=> (century_q != $past(century_q)));
  // R6
  month_start_chk: assert property (@(posedge clk) disable iff (rst)
    month_pulse |-> (mday_q == 6'h01));
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int SUBSEC_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       sec_pulse,
  output logic       min_pulse,
  output logic       hour_pulse,
  output logic       month_pulse
);
  logic       wr_sec, wr_min, wr_hour, wr_wday, wr_mday, wr_mon, wr_year, wr_mode;
  logic       sec_tick, day_step, mode24;
  logic [6:0] sec_q, min_q;
  logic [5:0] hour_q, mday_q;
  logic [2:0] wday_q;
  logic [4:0] mon_q;
  logic [7:0] year_q;
  logic       century_q;

  assign wr_sec  = wr_en && (wr_addr == ADDR_SEC);
  assign wr_min  = wr_en && (wr_addr == ADDR_MIN);
  assign wr_hour = wr_en && (wr_addr == ADDR_HOUR);
  assign wr_wday = wr_en && (wr_addr == ADDR_WDAY);
  assign wr_mday = wr_en && (wr_addr == ADDR_MDAY);
  assign wr_mon  = wr_en && (wr_addr == ADDR_MON);
  assign wr_year = wr_en && (wr_addr == ADDR_YEAR);
  assign wr_mode = wr_en && (wr_addr == ADDR_MODE);

  rtc_subsec_div #(.SUBSEC_DIV(SUBSEC_DIV)) u_div (
    .clk(clk), .rst(rst), .tick(tick), .clear(wr_sec), .sec_tick(sec_tick)
  );

  rtc_time_chain u_time (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .mode24(mode24),
    .wr_sec(wr_sec), .wr_min(wr_min), .wr_hour(wr_hour), .wr_data(wr_data),
    .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .day_step(day_step),
    .sec_pulse(sec_pulse), .min_pulse(min_pulse), .hour_pulse(hour_pulse)
  );

  rtc_date_chain u_date (
    .clk(clk), .rst(rst), .day_step(day_step),
    .wr_wday(wr_wday), .wr_mday(wr_mday), .wr_mon(wr_mon), .wr_year(wr_year),
    .wr_data(wr_data), .wday_q(wday_q), .mday_q(mday_q), .mon_q(mon_q),
    .year_q(year_q), .century_q(century_q), .month_pulse(month_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst)          mode24 <= 1'b0;
    else if (wr_mode) mode24 <= wr_data[0];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= 8'h00;
    else begin
      case (rd_addr)
        ADDR_SEC:  rd_data <= {1'b0, sec_q};
        ADDR_MIN:  rd_data <= {1'b0, min_q};
        ADDR_HOUR: rd_data <= {2'b00, hour_q};
        ADDR_WDAY: rd_data <= {5'b00000, wday_q};
        ADDR_MDAY: rd_data <= {2'b00, mday_q};
        ADDR_MON:  rd_data <= {century_q, 2'b00, mon_q};
        ADDR_YEAR: rd_data <= year_q;
        default:   rd_data <= {7'b0000000, mode24};
      endcase
    end
  end

  // R11
  mode_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ADDR_MODE) |=> (rd_data[7:1] == 7'b0000000));
  // R3
  day_step_chk: assert property (@(posedge clk) disable iff (rst)
    day_step |-> (hour_pulse == 1'b0 && sec_tick));
endmodule

// File: tb/rtc_calendar_core_test.sv
module rtc_calendar_core_test;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;
  logic sec_pulse, min_pulse, hour_pulse, month_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int m_sec, m_min, m_hr, m_wday, m_mday, m_mon, m_year, m_cent, m_mode24;

  always #5 clk = ~clk;

  rtc_calendar_core #(.SUBSEC_DIV(DIV)) uut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sec_pulse(sec_pulse), .min_pulse(min_pulse), .hour_pulse(hour_pulse),
    .month_pulse(month_pulse)
  );

  function automatic int to_bcd(int v);
    return (v / 10) * 16 + (v % 10);
  endfunction

  function automatic int mlen(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hour_code();
    int h12;
    if (m_mode24 != 0) return 8'(to_bcd(m_hr));
    h12 = (m_hr % 12 == 0) ? 12 : m_hr % 12;
    return 8'(((m_hr >= 12) ? 32 : 0) + to_bcd(h12));
  endfunction

  function automatic logic [7:0] exp_reg(int a);
    case (a)
      0: return 8'(to_bcd(m_sec));
      1: return 8'(to_bcd(m_min));
      2: return hour_code();
      3: return 8'(m_wday);
      4: return 8'(to_bcd(m_mday));
      5: return 8'(m_cent * 128 + to_bcd(m_mon));
      6: return 8'(to_bcd(m_year));
      default: return 8'(m_mode24);
    endcase
  endfunction

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic model_second(output bit pm, output bit ph, output bit pmo);
    pm = 0; ph = 0; pmo = 0;
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++; pm = 1;
      if (m_min == 60) begin
        m_min = 0; m_hr++; ph = 1;
        if (m_hr == 24) begin
          m_hr = 0; m_wday = (m_wday + 1) % 7; m_mday++;
          if (m_mday > mlen(m_mon, m_year)) begin
            m_mday = 1; m_mon++; pmo = 1;
            if (m_mon > 12) begin
              m_mon = 1; m_year++;
              if (m_year == 100) begin m_year = 0; m_cent ^= 1; end
            end
          end
        end
      end
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    rd_addr = 3'(a);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic verify_all(string req);
    int d;
    for (int a = 0; a < 8; a++) begin
      rd(a, d);
      check(req, d, exp_reg(a));
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  // one second: strobes sampled right after the edge carrying the last tick
  task automatic adv_sec();
    bit pm, ph, pmo;
    for (int i = 0; i < DIV - 1; i++) pulse_tick();
    check("R8 early", sec_pulse, 0);
    pulse_tick();
    model_second(pm, ph, pmo);
    check("R10 sec", sec_pulse, 1);
    check("R10 min", min_pulse, pm);
    check("R10 hour", hour_pulse, ph);
    check("R10 month", month_pulse, pmo);
  endtask

  task automatic load_model();
    wr(7, m_mode24);
    wr(1, to_bcd(m_min));
    wr(2, hour_code());
    wr(3, m_wday);
    wr(4, to_bcd(m_mday));
    wr(5, m_cent * 128 + to_bcd(m_mon));
    wr(6, to_bcd(m_year));
    wr(0, to_bcd(m_sec));
  endtask

  task automatic set_time(int mode, int yr, int mon, int md, int wd, int hr, int mi, int s, int c);
    m_mode24 = mode; m_year = yr; m_mon = mon; m_mday = md; m_wday = wd;
    m_hr = hr; m_min = mi; m_sec = s; m_cent = c;
    load_model();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int d;
    process::self().srandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    m_sec = 0; m_min = 0; m_hr = 0; m_wday = 0; m_mday = 1; m_mon = 1;
    m_year = 0; m_cent = 0; m_mode24 = 0;
    check("R1 strobes", {sec_pulse, min_pulse, hour_pulse, month_pulse}, 0);
    verify_all("R1");

    // R2 second and minute wrap
    set_time(1, 10, 5, 10, 2, 7, 58, 58, 0);
    repeat (3) adv_sec();
    verify_all("R2");

    // R3 24-hour day carry
    set_time(1, 10, 5, 10, 2, 23, 59, 59, 0);
    adv_sec();
    verify_all("R3");

    // R4 12-hour: AM11 -> PM12, PM12 -> PM01, PM11 -> AM12 with day carry
    set_time(0, 10, 5, 10, 6, 11, 59, 59, 0);
    adv_sec(); verify_all("R4 am11");
    set_time(0, 10, 5, 10, 6, 12, 59, 59, 0);
    adv_sec(); verify_all("R4 pm12");
    set_time(0, 10, 5, 10, 6, 23, 59, 59, 0);
    adv_sec(); verify_all("R4 pm11 R5");

    // R6 month lengths
    set_time(1, 24, 2, 28, 1, 23, 59, 59, 0); adv_sec(); verify_all("R6 leap28");
    adv_sec();
    set_time(1, 24, 2, 29, 1, 23, 59, 59, 0); adv_sec(); verify_all("R6 leap29");
    set_time(1, 23, 2, 28, 1, 23, 59, 59, 0); adv_sec(); verify_all("R6 plain28");
    set_time(1, 0, 2, 28, 1, 23, 59, 59, 1);  adv_sec(); verify_all("R6 year00");
    set_time(1, 23, 4, 30, 1, 23, 59, 59, 0); adv_sec(); verify_all("R6 apr30");
    set_time(1, 23, 7, 30, 1, 23, 59, 59, 0); adv_sec(); verify_all("R6 jul30");

    // R7 year and century wrap
    set_time(1, 99, 12, 31, 3, 23, 59, 59, 0); adv_sec(); verify_all("R7 cent0");
    set_time(1, 99, 12, 31, 3, 23, 59, 59, 1); adv_sec(); verify_all("R7 cent1");

    // R8 and R9: seconds write in the cycle of a divider wrap
    set_time(1, 30, 6, 15, 4, 10, 20, 30, 0);
    for (int i = 0; i < DIV - 1; i++) pulse_tick();
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h05;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    check("R9 sec write wins pulse", sec_pulse, 0);
    m_sec = 5;
    for (int i = 0; i < DIV - 1; i++) pulse_tick();
    rd(0, d); check("R8 divider cleared", d, 8'h05);
    pulse_tick();
    check("R8 advance", sec_pulse, 1);
    m_sec = 6;
    verify_all("R8");

    // R9 minute write with carry into it: carry out dropped
    set_time(1, 30, 6, 15, 4, 10, 59, 59, 0);
    for (int i = 0; i < DIV - 1; i++) pulse_tick();
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h45;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    check("R9 hour strobe dropped", hour_pulse, 0);
    m_sec = 0; m_min = 45;
    verify_all("R9");

    // R11 unused bits read as zero
    wr(7, 8'hFF); m_mode24 = 1;
    rd(7, d); check("R11 mode", d, 8'h01);
    wr(4, 8'hD7); rd(4, d); check("R11 mday mask", d, 8'h17);

    // random loads and runs
    for (int it = 0; it < 30; it++) begin
      int n;
      m_mode24 = $urandom % 2;
      m_year = $urandom % 100;
      m_mon = 1 + $urandom % 12;
      m_mday = ($urandom % 3 == 0) ? mlen(m_mon, m_year) : 1 + $urandom % mlen(m_mon, m_year);
      m_wday = $urandom % 7;
      m_hr = ($urandom % 2 == 0) ? 23 : $urandom % 24;
      m_min = ($urandom % 2 == 0) ? 59 : $urandom % 60;
      m_sec = 40 + $urandom % 20;
      m_cent = $urandom % 2;
      load_model();
      n = 1 + $urandom % 40;
      for (int k = 0; k < n; k++) adv_sec();
      verify_all("R2 R6 random");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule